// File: doc/BRIEF.md
# System Control Register File with Privilege Gating

This block holds the system-control registers that a processor core reaches through its move-to-coprocessor and move-from-coprocessor operations. Each access carries a four-field address (primary register number, first opcode, secondary register number, second opcode), a read/write direction and a flag that says whether the core is in a privileged mode. A read returns 32-bit data one cycle later. When the address does not decode to a readable register, or the core lacks the right to read it, the read returns zero and raises an error flag for that one cycle.

Writes update the selected storage register on the clock edge that samples them. Cache, TLB, barrier and prefetch-flush encodings have no storage. A permitted write to one of them is reported to the rest of the core as a one-cycle maintenance strobe that carries the packed address and the written value. Most registers need privilege. The two user thread-ID registers can be read from user mode, and the user read/write thread ID, the two barriers and the prefetch flush can also be written from user mode. A write that lacks permission is dropped and gives no indication.

Top module: `scr_file`

## Requirements
- R1: After synchronous reset, all outputs are zero. Privileged reads then return: main ID (0,0,0,0)=0x410FB024, control (1,0,0,0)=0x00054078, auxiliary control (1,0,0,1)=0x0000000F, cache lockdown (9,0,0,0)=0xFFFFFFF0, primary remap (10,0,2,0)=0x00098AA4 and normal remap (10,0,2,1)=0x44E048E0. Translation base/control, domain access, thread-ID and all other storage registers read zero.
- R2: A read that is permitted and that decodes to a register sets rd_valid in the next cycle, with rd_err low and rd_data equal to the register's value.
- R3: A privileged write to a writable storage register, such as (2,0,0,1) or (6,0,0,0), changes it on the sampling edge. A read issued in the following cycle returns the new value.
- R4: In user mode only (13,0,0,2), the user read/write thread ID, and (13,0,0,3), the user read-only thread ID, can be read. Every other user read returns zero with rd_err high.
- R5: The user read/write thread ID accepts writes in both modes. A user-mode write to the user read-only thread ID, or to any other privileged register, leaves that register unchanged.
- R6: A privileged write to a maintenance encoding produces mt_valid for one cycle in the next cycle. mt_code={CRn[3:0],opc1[2:0],CRm[3:0],opc2[2:0]} and mt_data holds the written value. The maintenance encodings are: (7,0,0,4); (7,0,5,{0,1,2,4,6,7}); (7,0,6,{0,1,2}); (7,0,7,0); (7,0,10,{0,1,2,4,5}); (7,0,14,{0,1,2}); (8,0,{5,6,7},{0..3}); (15,5,4,{2,4}). A read of any of these returns zero with rd_err.
- R7: Prefetch flush (7,0,5,4) and the two barriers (7,0,10,4) and (7,0,10,5) produce a maintenance strobe from user mode. Any other maintenance encoding written from user mode produces no strobe.
- R8: Writes to the main ID register and to the physical-address register (7,0,4,0) are ignored. Both stay readable in privileged mode.
- R9: A read of an address that decodes to nothing returns rd_data zero with rd_err high, and rd_err is never high without rd_valid. A write to such an address changes nothing and produces no strobe.
- R10: The performance monitor control, cycle counter and two event counters at (15,0,12,0..3) can be read and written in privileged mode.
- R11: rd_valid is high exactly in the cycle after a read access and rd_data is zero when rd_valid is low. mt_valid is high only in the cycle after a permitted maintenance write. Accesses may be issued back to back, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write (move to), 0 = read (move from) |
| acc_priv | input | 1 | Requester is in a privileged mode |
| acc_crn | input | 4 | Primary register number |
| acc_opc1 | input | 3 | First opcode |
| acc_crm | input | 4 | Secondary register number |
| acc_opc2 | input | 3 | Second opcode |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read data, zero on error |
| rd_err | output | 1 | Read had no decode or no permission |
| mt_valid | output | 1 | Maintenance operation strobe |
| mt_code | output | 14 | Packed address of the maintenance operation |
| mt_data | output | 32 | Value written with the maintenance operation |

## Verification
The assertions check on every cycle that read responses line up with read requests, that an error response always carries zero data, that user-mode reads outside the two thread-ID registers fail, that user-mode writes to protected maintenance encodings and to the read-only thread ID never reach storage or the strobe, and that a granted write lands in the addressed register. Only the bench's scenarios show the actual reset constants, the data read back after writes in each mode, the ignored writes to the ID and physical-address registers, and the exact maintenance codes and data.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int DW     = 32;
    localparam int CRN_W  = 4;
    localparam int OP1_W  = 3;
    localparam int CRM_W  = 4;
    localparam int OP2_W  = 3;
    localparam int ADDR_W = CRN_W + OP1_W + CRM_W + OP2_W;
    localparam int NREG   = 30;
    localparam int IDX_W  = $clog2(NREG);

    typedef enum logic [IDX_W-1:0] {
        ID_MAIN, SC_CTRL, SC_AUX, SC_CPACC, TT_BASE0, TT_BASE1, TT_CTRL,
        DOM_ACC, FLT_DATA, FLT_INSTR, FLT_ADDR, FLT_WADDR, PHYS_ADDR,
        DC_LOCK, TLB_LOCK, REMAP_PRI, REMAP_NRM, PROC_ID, CTX_ID,
        TID_URW, TID_URO, TID_PRW, PM_CTRL, PM_CYC, PM_EV0, PM_EV1,
        LTLB_VA, LTLB_PA, LTLB_ATTR, TLB_DBG
    } reg_id_e;

    typedef struct packed {
        logic [CRN_W-1:0] crn;
        logic [OP1_W-1:0] op1;
        logic [CRM_W-1:0] crm;
        logic [OP2_W-1:0] op2;
    } cp_addr_t;

    typedef struct packed {
        logic    is_reg;
        reg_id_e idx;
        logic    rd_user;
        logic    wr_user;
        logic    wr_drop;
        logic    is_maint;
    } dec_t;

    function automatic logic [DW-1:0] reset_value(input int unsigned i);
        case (i)
            int'(ID_MAIN):   return 32'h410F_B024;
            int'(SC_CTRL):   return 32'h0005_4078;
            int'(SC_AUX):    return 32'h0000_000F;
            int'(DC_LOCK):   return 32'hFFFF_FFF0;
            int'(REMAP_PRI): return 32'h0009_8AA4;
            int'(REMAP_NRM): return 32'h44E0_48E0;
            default:         return '0;
        endcase
    endfunction

    function automatic dec_t decode(input cp_addr_t a);
        dec_t d;
        d        = '0;
        d.is_reg = 1'b1;
        case (a)
            {4'd0,  3'd0, 4'd0,  3'd0}: d.idx = ID_MAIN;
            {4'd1,  3'd0, 4'd0,  3'd0}: d.idx = SC_CTRL;
            {4'd1,  3'd0, 4'd0,  3'd1}: d.idx = SC_AUX;
            {4'd1,  3'd0, 4'd0,  3'd2}: d.idx = SC_CPACC;
            {4'd2,  3'd0, 4'd0,  3'd0}: d.idx = TT_BASE0;
            {4'd2,  3'd0, 4'd0,  3'd1}: d.idx = TT_BASE1;
            {4'd2,  3'd0, 4'd0,  3'd2}: d.idx = TT_CTRL;
            {4'd3,  3'd0, 4'd0,  3'd0}: d.idx = DOM_ACC;
            {4'd5,  3'd0, 4'd0,  3'd0}: d.idx = FLT_DATA;
            {4'd5,  3'd0, 4'd0,  3'd1}: d.idx = FLT_INSTR;
            {4'd6,  3'd0, 4'd0,  3'd0}: d.idx = FLT_ADDR;
            {4'd6,  3'd0, 4'd0,  3'd1}: d.idx = FLT_WADDR;
            {4'd7,  3'd0, 4'd4,  3'd0}: d.idx = PHYS_ADDR;
            {4'd9,  3'd0, 4'd0,  3'd0}: d.idx = DC_LOCK;
            {4'd10, 3'd0, 4'd0,  3'd0}: d.idx = TLB_LOCK;
            {4'd10, 3'd0, 4'd2,  3'd0}: d.idx = REMAP_PRI;
            {4'd10, 3'd0, 4'd2,  3'd1}: d.idx = REMAP_NRM;
            {4'd13, 3'd0, 4'd0,  3'd0}: d.idx = PROC_ID;
            {4'd13, 3'd0, 4'd0,  3'd1}: d.idx = CTX_ID;
            {4'd13, 3'd0, 4'd0,  3'd2}: d.idx = TID_URW;
            {4'd13, 3'd0, 4'd0,  3'd3}: d.idx = TID_URO;
            {4'd13, 3'd0, 4'd0,  3'd4}: d.idx = TID_PRW;
            {4'd15, 3'd0, 4'd12, 3'd0}: d.idx = PM_CTRL;
            {4'd15, 3'd0, 4'd12, 3'd1}: d.idx = PM_CYC;
            {4'd15, 3'd0, 4'd12, 3'd2}: d.idx = PM_EV0;
            {4'd15, 3'd0, 4'd12, 3'd3}: d.idx = PM_EV1;
            {4'd15, 3'd5, 4'd5,  3'd2}: d.idx = LTLB_VA;
            {4'd15, 3'd5, 4'd6,  3'd2}: d.idx = LTLB_PA;
            {4'd15, 3'd5, 4'd7,  3'd2}: d.idx = LTLB_ATTR;
            {4'd15, 3'd7, 4'd1,  3'd0}: d.idx = TLB_DBG;
            default:                    d.is_reg = 1'b0;
        endcase
        if (d.is_reg) begin
            d.rd_user = (d.idx == TID_URW) || (d.idx == TID_URO);
            d.wr_user = (d.idx == TID_URW);
            d.wr_drop = (d.idx == ID_MAIN) || (d.idx == PHYS_ADDR);
        end
        case (a)
            {4'd7, 3'd0, 4'd5,  3'd4},
            {4'd7, 3'd0, 4'd10, 3'd4},
            {4'd7, 3'd0, 4'd10, 3'd5}: begin
                d.is_maint = 1'b1;
                d.wr_user  = 1'b1;
            end
            {4'd7, 3'd0, 4'd0,  3'd4},
            {4'd7, 3'd0, 4'd5,  3'd0}, {4'd7, 3'd0, 4'd5,  3'd1},
            {4'd7, 3'd0, 4'd5,  3'd2}, {4'd7, 3'd0, 4'd5,  3'd6},
            {4'd7, 3'd0, 4'd5,  3'd7},
            {4'd7, 3'd0, 4'd6,  3'd0}, {4'd7, 3'd0, 4'd6,  3'd1},
            {4'd7, 3'd0, 4'd6,  3'd2},
            {4'd7, 3'd0, 4'd7,  3'd0},
            {4'd7, 3'd0, 4'd10, 3'd0}, {4'd7, 3'd0, 4'd10, 3'd1},
            {4'd7, 3'd0, 4'd10, 3'd2},
            {4'd7, 3'd0, 4'd14, 3'd0}, {4'd7, 3'd0, 4'd14, 3'd1},
            {4'd7, 3'd0, 4'd14, 3'd2},
            {4'd15, 3'd5, 4'd4, 3'd2}, {4'd15, 3'd5, 4'd4, 3'd4}:
                d.is_maint = 1'b1;
            default:
                d.is_maint = (a.crn == 4'd8) && (a.op1 == 3'd0) &&
                             (a.crm >= 4'd5) && (a.crm <= 4'd7) &&
                             (a.op2 <= 3'd3);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/scr_decode.sv
module scr_decode
    import scr_pkg::*;
(
    input  logic     valid,
    input  logic     write,
    input  logic     priv,
    input  cp_addr_t addr,
    output logic     rd_ok,
    output reg_id_e  idx,
    output logic     wr_en,
    output logic     mt_fire
);
    dec_t d;

    always_comb begin
        d       = decode(addr);
        idx     = d.idx;
        rd_ok   = valid && !write && d.is_reg && (priv || d.rd_user);
        wr_en   = valid && write && d.is_reg && !d.wr_drop && (priv || d.wr_user);
        mt_fire = valid && write && d.is_maint && (priv || d.wr_user);
    end
endmodule

// File: rtl/scr_regbank.sv
module scr_regbank
    import scr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_id_e       idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] bank [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == int'(ID_MAIN)) begin : g_const
            assign bank[i] = reset_value(i);
        end else begin : g_store
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= reset_value(i);
                else if (wr_en && (int'(idx) == i))
                    q <= wdata;
            end
            assign bank[i] = q;
        end
    end

    assign rdata = bank[idx];

    // R3: a granted write lands in the addressed storage register
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx != ID_MAIN) |=> bank[$past(idx)] == $past(wdata));
endmodule

// File: rtl/scr_file.sv
module scr_file
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_priv,
    input  logic [CRN_W-1:0]  acc_crn,
    input  logic [OP1_W-1:0]  acc_opc1,
    input  logic [CRM_W-1:0]  acc_crm,
    input  logic [OP2_W-1:0]  acc_opc2,
    input  logic [DW-1:0]     acc_wdata,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              rd_err,
    output logic              mt_valid,
    output logic [ADDR_W-1:0] mt_code,
    output logic [DW-1:0]     mt_data
);
    cp_addr_t      addr;
    reg_id_e       idx;
    logic          rd_ok, wr_en, mt_fire;
    logic [DW-1:0] bank_q;
    logic          is_read;

    assign addr    = '{crn: acc_crn, op1: acc_opc1, crm: acc_crm, op2: acc_opc2};
    assign is_read = acc_valid && !acc_write;

    scr_decode u_dec (
        .valid   (acc_valid),
        .write   (acc_write),
        .priv    (acc_priv),
        .addr    (addr),
        .rd_ok   (rd_ok),
        .idx     (idx),
        .wr_en   (wr_en),
        .mt_fire (mt_fire)
    );

    scr_regbank u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .idx   (idx),
        .wdata (acc_wdata),
        .rdata (bank_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_err   <= 1'b0;
            mt_valid <= 1'b0;
            mt_code  <= '0;
            mt_data  <= '0;
        end else begin
            rd_valid <= is_read;
            rd_data  <= rd_ok ? bank_q : '0;
            rd_err   <= is_read && !rd_ok;
            mt_valid <= mt_fire;
            mt_code  <= mt_fire ? addr : '0;
            mt_data  <= mt_fire ? acc_wdata : '0;
        end
    end

    // R9: an error response always carries zero data and a valid
    assert_err_zero_R9: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_valid && rd_data == '0));

    // R11: one response per read request, none otherwise
    assert_rsp_align_R11: assert property (@(posedge clk) disable iff (rst)
        is_read |=> rd_valid);
    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (rst)
        !is_read |=> !rd_valid);

    // R4: user reads outside the two thread-ID registers fail
    assert_user_read_R4: assert property (@(posedge clk) disable iff (rst)
        (is_read && !acc_priv && !(acc_crn == 4'd13 && acc_opc1 == 3'd0 &&
         acc_crm == 4'd0 && (acc_opc2 == 3'd2 || acc_opc2 == 3'd3))) |=> rd_err);

    // R5: user-mode write to the read-only thread ID never reaches storage
    assert_uro_protect_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !acc_priv && acc_crn == 4'd13 &&
         acc_opc1 == 3'd0 && acc_crm == 4'd0 && acc_opc2 == 3'd3) |-> !wr_en);

    // R7: user-mode cache invalidate encodings produce no strobe
    assert_user_maint_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !acc_priv && acc_crn == 4'd7 &&
         acc_opc1 == 3'd0 && acc_crm == 4'd6) |=> !mt_valid);
endmodule

// File: tb/scr_file_test.sv
module scr_file_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0;
    logic [3:0]  acc_crn = '0, acc_crm = '0;
    logic [2:0]  acc_opc1 = '0, acc_opc2 = '0;
    logic [31:0] acc_wdata = '0;
    logic        rd_valid, rd_err, mt_valid;
    logic [31:0] rd_data, mt_data;
    logic [13:0] mt_code;

    always #10 clk = ~clk;

    scr_file uut (.*);

    int vectors = 0, miscompares = 0;

    // reference state: readable registers keyed by packed address
    logic [31:0] mem [int];
    bit          mset [int];
    bit          uset [int];

    // pending expectation for the next sampled cycle
    bit          e_rv = 0, e_re = 0, e_mv = 0;
    logic [31:0] e_rd = 0, e_md = 0;
    logic [13:0] e_mc = 0;
    string       e_tag = "R1";

    function automatic int ad(int crn, int op1, int crm, int op2);
        return (crn << 10) | (op1 << 7) | (crm << 3) | op2;
    endfunction

    localparam int A_MAIN = (0 << 10);
    localparam int A_PHYS = (7 << 10) | (4 << 3);
    localparam int A_URW  = (13 << 10) | 2;
    localparam int A_URO  = (13 << 10) | 3;

    task automatic cmp1(string f, logic [31:0] got, logic [31:0] exp, inout bit bad);
        if (got !== exp) begin
            $display("FAIL %s %s: got %h expected %h", e_tag, f, got, exp);
            bad = 1;
        end
    endtask

    task automatic check_now();
        bit bad = 0;
        vectors++;
        cmp1("rd_valid", 32'(rd_valid), 32'(e_rv), bad);
        cmp1("rd_data",  rd_data, e_rd, bad);
        cmp1("rd_err",   32'(rd_err), 32'(e_re), bad);
        cmp1("mt_valid", 32'(mt_valid), 32'(e_mv), bad);
        cmp1("mt_code",  32'(mt_code), 32'(e_mc), bad);
        cmp1("mt_data",  mt_data, e_md, bad);
        if (bad) miscompares++;
    endtask

    task automatic step(bit v, bit w, bit p, int crn, int op1, int crm, int op2,
                        logic [31:0] d, string tag);
        int a = ad(crn, op1, crm, op2);
        check_now();
        acc_valid = v; acc_write = w; acc_priv = p;
        acc_crn = 4'(crn); acc_opc1 = 3'(op1); acc_crm = 4'(crm); acc_opc2 = 3'(op2);
        acc_wdata = d;
        e_tag = tag;
        e_rv = v && !w; e_re = 0; e_rd = 0; e_mv = 0; e_mc = 0; e_md = 0;
        if (v && !w) begin
            if (mem.exists(a) && (p || a == A_URW || a == A_URO)) e_rd = mem[a];
            else e_re = 1;
        end
        if (v && w) begin
            if (mem.exists(a) && a != A_MAIN && a != A_PHYS && (p || a == A_URW))
                mem[a] = d;
            if (mset.exists(a) && (p || uset.exists(a))) begin
                e_mv = 1; e_mc = 14'(a); e_md = d;
            end
        end
        @(negedge clk);
    endtask

    task automatic rd(bit p, int crn, int op1, int crm, int op2, string tag);
        step(1, 0, p, crn, op1, crm, op2, 32'h0, tag);
    endtask

    task automatic wr(bit p, int crn, int op1, int crm, int op2, logic [31:0] d, string tag);
        step(1, 1, p, crn, op1, crm, op2, d, tag);
    endtask

    task automatic model_init();
        int regs [$] = '{ad(0,0,0,0), ad(1,0,0,0), ad(1,0,0,1), ad(1,0,0,2),
            ad(2,0,0,0), ad(2,0,0,1), ad(2,0,0,2), ad(3,0,0,0), ad(5,0,0,0),
            ad(5,0,0,1), ad(6,0,0,0), ad(6,0,0,1), ad(7,0,4,0), ad(9,0,0,0),
            ad(10,0,0,0), ad(10,0,2,0), ad(10,0,2,1), ad(13,0,0,0), ad(13,0,0,1),
            ad(13,0,0,2), ad(13,0,0,3), ad(13,0,0,4), ad(15,0,12,0), ad(15,0,12,1),
            ad(15,0,12,2), ad(15,0,12,3), ad(15,5,5,2), ad(15,5,6,2), ad(15,5,7,2),
            ad(15,7,1,0)};
        foreach (regs[k]) mem[regs[k]] = 32'h0;
        mem[ad(0,0,0,0)]  = 32'h410F_B024;
        mem[ad(1,0,0,0)]  = 32'h0005_4078;
        mem[ad(1,0,0,1)]  = 32'h0000_000F;
        mem[ad(9,0,0,0)]  = 32'hFFFF_FFF0;
        mem[ad(10,0,2,0)] = 32'h0009_8AA4;
        mem[ad(10,0,2,1)] = 32'h44E0_48E0;
        mset[ad(7,0,0,4)] = 1;
        foreach (regs[k]) begin end
        for (int o = 0; o < 8; o++) if (o != 3 && o != 5) mset[ad(7,0,5,o)] = 1;
        for (int o = 0; o < 3; o++) begin
            mset[ad(7,0,6,o)] = 1; mset[ad(7,0,10,o)] = 1; mset[ad(7,0,14,o)] = 1;
        end
        mset[ad(7,0,7,0)] = 1; mset[ad(7,0,10,4)] = 1; mset[ad(7,0,10,5)] = 1;
        for (int m = 5; m < 8; m++) for (int o = 0; o < 4; o++) mset[ad(8,0,m,o)] = 1;
        mset[ad(15,5,4,2)] = 1; mset[ad(15,5,4,4)] = 1;
        uset[ad(7,0,5,4)] = 1; uset[ad(7,0,10,4)] = 1; uset[ad(7,0,10,5)] = 1;
    endtask

    initial begin
        model_init();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs idle after reset, then reset constants
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        rd(1, 0,0,0,0, "R1"); rd(1, 1,0,0,0, "R1"); rd(1, 1,0,0,1, "R1");
        rd(1, 9,0,0,0, "R1"); rd(1, 10,0,2,0, "R1"); rd(1, 10,0,2,1, "R1");
        rd(1, 2,0,0,0, "R1"); rd(1, 3,0,0,0, "R1"); rd(1, 13,0,0,2, "R1");
        rd(1, 13,0,0,3, "R1"); rd(1, 13,0,0,4, "R1");
        // R3 / R2: privileged writes then reads back-to-back
        wr(1, 2,0,0,1, 32'hCAFE_0001, "R3"); rd(1, 2,0,0,1, "R2");
        wr(1, 6,0,0,0, 32'h1234_5678, "R3"); rd(1, 6,0,0,0, "R2");
        wr(1, 1,0,0,0, 32'h0000_0005, "R3"); rd(1, 1,0,0,0, "R2");
        wr(1, 15,7,1,0, 32'h0BAD_F00D, "R3"); rd(1, 15,7,1,0, "R2");
        // R10: performance monitor group
        for (int o = 0; o < 4; o++) wr(1, 15,0,12,o, 32'hA000_0000 + o, "R10");
        for (int o = 0; o < 4; o++) rd(1, 15,0,12,o, "R10");
        // R4: user reads
        rd(0, 13,0,0,2, "R4"); rd(0, 13,0,0,3, "R4"); rd(0, 1,0,0,0, "R4");
        rd(0, 15,0,12,1, "R4"); rd(0, 13,0,0,4, "R4");
        // R5: user writes
        wr(0, 13,0,0,2, 32'h5555_AAAA, "R5"); rd(0, 13,0,0,2, "R5");
        wr(0, 13,0,0,3, 32'h1111_1111, "R5"); rd(0, 13,0,0,3, "R5");
        wr(0, 1,0,0,1, 32'hFFFF_FFFF, "R5"); rd(1, 1,0,0,1, "R5");
        wr(1, 13,0,0,3, 32'h7777_0000, "R5"); rd(0, 13,0,0,3, "R5");
        // R6: privileged maintenance strobes and write-only reads
        wr(1, 7,0,5,0, 32'h0000_00C1, "R6"); wr(1, 8,0,6,3, 32'h0000_00C2, "R6");
        wr(1, 15,5,4,2, 32'h0000_00C3, "R6"); wr(1, 7,0,14,2, 32'h0000_00C4, "R6");
        rd(1, 7,0,14,1, "R6"); rd(1, 8,0,7,0, "R6");
        // R7: user-mode maintenance
        wr(0, 7,0,10,4, 32'h0000_0D01, "R7"); wr(0, 7,0,10,5, 32'h0000_0D02, "R7");
        wr(0, 7,0,5,4, 32'h0000_0D03, "R7"); wr(0, 7,0,6,0, 32'h0000_0D04, "R7");
        wr(0, 8,0,5,0, 32'h0000_0D05, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R7");
        // R8: ignored writes
        wr(1, 7,0,4,0, 32'hDEAD_BEEF, "R8"); rd(1, 7,0,4,0, "R8");
        wr(1, 0,0,0,0, 32'h0000_0000, "R8"); rd(1, 0,0,0,0, "R8");
        // R9: undecoded addresses
        rd(1, 0,0,0,7, "R9"); rd(1, 11,0,0,0, "R9"); rd(1, 13,1,0,2, "R9");
        wr(1, 11,0,0,0, 32'h9999_9999, "R9"); rd(1, 11,0,0,0, "R9");
        // R11: mixed back-to-back traffic and idle gaps
        rd(1, 10,0,2,0, "R11"); wr(1, 3,0,0,0, 32'h0000_0F0F, "R11");
        rd(1, 3,0,0,0, "R11"); step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
        step(0, 1, 1, 7, 0, 5, 0, 32'h1, "R11");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
        check_now();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        miscompares++;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule